// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a small serial EEPROM that a host drives over a three-wire serial link: a select line, a serial clock and a data input, plus a data output the block drives only when it has status to report. The select, clock and data pins are brought into the system clock domain through synchronizers. The block then looks for rising edges of the serial clock and assembles an instruction from the bits it samples there. An instruction opens with a logic-1 start bit and a two-bit opcode. An address follows, and for a program instruction a data word comes last. Both the address and the data arrive most significant bit first.

Three instructions are decoded. The program-control instruction grants or revokes permission to modify storage. The word write instruction replaces a word, and the word erase instruction sets one word to all ones. When a complete write or erase arrives while programming is permitted, the falling edge of select starts a self-timed program cycle of a fixed number of system clocks. No serial clock activity is needed during that cycle. A write first clears the target word to all ones and stores the new value when the cycle ends. Whenever the host selects the device after a cycle has begun, the data output reports busy and then ready. A read-only parallel port lets the surrounding logic inspect any stored word.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While the synchronized select is low, `sdo_en_o` is 0 (data output released).
- R2: From the accepted start bit until select falls, `sdo_en_o` is 0.
- R3: After reset programming is disabled and all words read 0. A write or erase issued while programming is disabled starts no cycle, leaves storage unchanged and produces no status on the data output.
- R4: The control instruction is start bit 1, opcode 00, then ADDR_W address bits. It enables programming when the two most significant address bits are 11 and disables it when they are 00. Any other value leaves the permission unchanged. The instruction takes effect at the falling edge of select.
- R5: A write instruction is start 1, opcode 01, ADDR_W address bits MSB first, then DATA_W data bits MSB first. When the program cycle ends, the word at that address holds the data.
- R6: During a write's program cycle the target word reads all ones (it is cleared before the store).
- R7: An erase instruction is start 1, opcode 11, then ADDR_W address bits. After its cycle every bit of the word is 1.
- R8: The program cycle lasts exactly PROG_CYCLES system clocks. While it runs and select is high, `sdo_o` is 0 (busy). After it ends, `sdo_o` is 1 (ready) while select is high, until the next start bit.
- R9: If select falls before a write (3+ADDR_W+DATA_W bits) or an erase or control instruction (3+ADDR_W bits) has been fully received, the instruction is dropped and nothing changes.
- R10: Serial input that arrives while a program cycle runs is ignored, and no second cycle starts from it.
- R11: The program cycle completes with the serial clock held still.
- R12: Zeros sampled before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Device select from host, active high |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Status bit: 0 busy, 1 ready |
| sdo_en_o | output | 1 | Output enable for the data-out pad |
| peek_addr_i | input | ADDR_W | Word address for the parallel inspection port |
| peek_data_o | output | DATA_W | Word stored at `peek_addr_i` |

## Verification
The assertions watch several properties on every cycle. The output stays released while deselected or mid-instruction. Busy always reads as 0. Each program cycle lasts exactly the configured length. A cycle starts only with permission set. No start bit is accepted while busy, and a truncated instruction never starts a cycle. The bench scenarios are needed for behaviour the assertions cannot see: the bit ordering of address and data, the stored values, the all-ones word during a write, the control codes that leave permission alone, and an erase arriving mid-cycle that leaves its word intact.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [1:0] {
        OP_CTRL  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RSVD  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    localparam logic [1:0] CTRL_ENABLE  = 2'b11;
    localparam logic [1:0] CTRL_DISABLE = 2'b00;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_s,
    output logic cs_fall,
    output logic sk_rise,
    output logic di_s
);

    typedef struct packed {
        logic [2:0] cs;
        logic [2:0] sk;
        logic [1:0] di;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.cs = {st_q.cs[1:0], cs_i};
        st_d.sk = {st_q.sk[1:0], sk_i};
        st_d.di = {st_q.di[0], di_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_s    = st_q.cs[1];
    assign cs_fall = st_q.cs[2] & ~st_q.cs[1];
    assign sk_rise = st_q.sk[1] & ~st_q.sk[2];
    assign di_s    = st_q.di[1];

endmodule

// File: rtl/mw_cmd_shift.sv
module mw_cmd_shift
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sk_rise,
    input  logic              di_s,
    input  logic              busy,
    output logic              shifting,
    output logic              start_seen,
    output logic [1:0]        op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              complete
);

    localparam int HDR_BITS  = 2 + ADDR_W;
    localparam int FULL_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W     = $clog2(FULL_BITS + 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        start_seen = 1'b0;
        if (!cs_s) begin
            st_d.active = 1'b0;
        end else if (sk_rise && !busy) begin
            if (!st_q.active) begin
                if (di_s) begin
                    st_d.active = 1'b1;
                    st_d.cnt    = '0;
                    st_d.op     = '0;
                    start_seen  = 1'b1;
                end
            end else if (st_q.cnt < CNT_W'(FULL_BITS)) begin
                if (st_q.cnt < CNT_W'(2)) begin
                    st_d.op = {st_q.op[0], di_s};
                end else if (st_q.cnt < CNT_W'(HDR_BITS)) begin
                    st_d.addr = {st_q.addr[ADDR_W-2:0], di_s};
                end else begin
                    st_d.data = {st_q.data[DATA_W-2:0], di_s};
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        complete = 1'b0;
        if (st_q.active) begin
            if (mw_op_e'(st_q.op) == OP_WRITE)
                complete = (st_q.cnt == CNT_W'(FULL_BITS));
            else if (mw_op_e'(st_q.op) != OP_RSVD)
                complete = (st_q.cnt >= CNT_W'(HDR_BITS));
        end
    end

    assign shifting = st_q.active;
    assign op       = st_q.op;
    assign addr     = st_q.addr;
    assign data     = st_q.data;

endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_fall,
    input  logic              start_seen,
    input  logic              complete,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              wen,
    output logic              sdo,
    output logic              sdo_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic              wen;
        logic              busy;
        logic              show;
        logic [TMR_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_addr  = st_q.addr;
        mem_wdata = st_q.data;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                mem_we    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (cs_fall && complete) begin
            case (mw_op_e'(op))
                OP_CTRL: begin
                    if (addr[ADDR_W-1 -: 2] == CTRL_ENABLE)
                        st_d.wen = 1'b1;
                    else if (addr[ADDR_W-1 -: 2] == CTRL_DISABLE)
                        st_d.wen = 1'b0;
                end
                OP_WRITE, OP_ERASE: begin
                    if (st_q.wen) begin
                        st_d.busy = 1'b1;
                        st_d.show = 1'b1;
                        st_d.cnt  = TMR_W'(PROG_CYCLES - 1);
                        st_d.addr = addr;
                        st_d.data = (mw_op_e'(op) == OP_WRITE) ? data : '1;
                        mem_we    = 1'b1;
                        mem_addr  = addr;
                        mem_wdata = '1;
                    end
                end
                default: ;
            endcase
        end
        if (start_seen) st_d.show = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign wen    = st_q.wen;
    assign sdo    = ~st_q.busy;
    assign sdo_en = cs_s & st_q.show;

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
        end else if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata = words_q[raddr];

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);

    logic              cs_s, cs_fall, sk_rise, di_s;
    logic              shifting, start_seen, complete;
    logic [1:0]        op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              busy, wen;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    mw_pin_sync i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (sel_i),
        .sk_i    (sclk_i),
        .di_i    (sdi_i),
        .cs_s    (cs_s),
        .cs_fall (cs_fall),
        .sk_rise (sk_rise),
        .di_s    (di_s)
    );

    mw_cmd_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sk_rise    (sk_rise),
        .di_s       (di_s),
        .busy       (busy),
        .shifting   (shifting),
        .start_seen (start_seen),
        .op         (op),
        .addr       (cmd_addr),
        .data       (cmd_data),
        .complete   (complete)
    );

    mw_prog_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .cs_fall    (cs_fall),
        .start_seen (start_seen),
        .complete   (complete),
        .op         (op),
        .addr       (cmd_addr),
        .data       (cmd_data),
        .busy       (busy),
        .wen        (wen),
        .sdo        (sdo_o),
        .sdo_en     (sdo_en_o),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (peek_addr_i),
        .rdata (peek_data_o)
    );

endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk #(
    parameter int PROG_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic cs_fall,
    input logic shifting,
    input logic start_seen,
    input logic complete,
    input logic busy,
    input logic wen,
    input logic sdo,
    input logic sdo_en
);

    logic [31:0] busy_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run_q <= '0;
        else if (busy) busy_run_q <= busy_run_q + 1;
        else           busy_run_q <= '0;
    end

    p_released_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !sdo_en);

    p_released_shifting_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |-> !sdo_en);

    p_cycle_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    p_busy_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && busy) |-> !sdo);

    p_cycle_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run_q == 32'(PROG_CYCLES)));

    p_truncated_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !complete && !busy) |=> !busy);

    p_no_start_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_seen);

endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .cs_fall    (cs_fall),
    .shifting   (shifting),
    .start_seen (start_seen),
    .complete   (complete),
    .busy       (busy),
    .wen        (wen),
    .sdo        (sdo_o),
    .sdo_en     (sdo_en_o)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;

    localparam int CLK_PERIOD = 10;
    localparam int A_W   = 8;
    localparam int D_W   = 16;
    localparam int PROG  = 300;
    localparam int HALF  = 4;
    localparam int NVEC  = 6;

    // {kind (0 write, 1 erase), address, data, expected word}
    localparam logic [41:0] VEC [NVEC] = '{
        {2'd0, 8'h00, 16'hA5C3, 16'hA5C3},
        {2'd0, 8'hFF, 16'h1234, 16'h1234},
        {2'd0, 8'h21, 16'h5A5A, 16'h5A5A},
        {2'd1, 8'hFF, 16'h0000, 16'hFFFF},
        {2'd0, 8'h7E, 16'h8001, 16'h8001},
        {2'd0, 8'h00, 16'h0000, 16'h0000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sel = 1'b0;
    logic           sclk = 1'b0;
    logic           sdi = 1'b0;
    logic           sdo, sdo_en;
    logic [A_W-1:0] peek_addr = '0;
    logic [D_W-1:0] peek_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_slave #(.ADDR_W(A_W), .DATA_W(D_W), .PROG_CYCLES(PROG)) i_mw_eeprom_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .sclk_i      (sclk),
        .sdi_i       (sdi),
        .sdo_o       (sdo),
        .sdo_en_o    (sdo_en),
        .peek_addr_i (peek_addr),
        .peek_data_o (peek_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        sdi = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic select_dev();
        sel = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic deselect_dev();
        sel = 1'b0;
        sdi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_ctrl(input logic [1:0] code);
        select_dev();
        send({1'b1, 2'b00, code, 6'b0}, 3 + A_W);
        deselect_dev();
    endtask

    task automatic do_write(input logic [A_W-1:0] a, input logic [D_W-1:0] d);
        select_dev();
        send({1'b1, 2'b01, a, d}, 3 + A_W + D_W);
        deselect_dev();
    endtask

    task automatic do_erase(input logic [A_W-1:0] a);
        select_dev();
        send({1'b1, 2'b11, a}, 3 + A_W);
        deselect_dev();
    endtask

    // Select, count busy cycles on the output, stop at ready. Serial clock stays low.
    task automatic wait_ready(output int low_cnt, output bit ready);
        low_cnt = 0;
        ready   = 1'b0;
        select_dev();
        for (int i = 0; i < 2000 && !ready; i++) begin
            @(negedge clk);
            if (sdo_en && !sdo) low_cnt++;
            if (sdo_en && sdo)  ready = 1'b1;
        end
        deselect_dev();
    endtask

    task automatic peek(input logic [A_W-1:0] a, output logic [D_W-1:0] v);
        peek_addr = a;
        @(negedge clk);
        v = peek_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [D_W-1:0] w;
        int  lows;
        bit  rdy;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state
        check("R1 released after reset", 32'(sdo_en), 32'd0);
        peek(8'h33, w);
        check("R3 word zero after reset", 32'(w), 32'h0);

        // R3: programming disabled at power-up
        do_write(8'h33, 16'hBEEF);
        select_dev();
        repeat (10) @(negedge clk);
        check("R3 no status when disabled", 32'(sdo_en), 32'd0);
        deselect_dev();
        peek(8'h33, w);
        check("R3 word unchanged when disabled", 32'(w), 32'h0);

        // R12: leading zeros before start, then enable (R4)
        select_dev();
        send(32'b000, 3);
        send({1'b1, 2'b00, 2'b11, 6'b0}, 3 + A_W);
        deselect_dev();
        do_write(8'h40, 16'h1111);
        wait_ready(lows, rdy);
        check("R12 enable after leading zeros, ready seen", 32'(rdy), 32'd1);
        peek(8'h40, w);
        check("R4 write stored after enable", 32'(w), 32'h1111);

        // R8 ready persists; R2 released after start; R9 truncated write
        select_dev();
        check("R8 ready shown before next start", 32'({sdo_en, sdo}), 32'b11);
        send({1'b1, 2'b01, 4'hA}, 7);
        check("R2 released while shifting", 32'(sdo_en), 32'd0);
        deselect_dev();
        select_dev();
        repeat (4) @(negedge clk);
        check("R9 truncated write starts no cycle", 32'(sdo_en), 32'd0);
        deselect_dev();
        peek(8'hA0, w);
        check("R9 storage unchanged", 32'(w), 32'h0);

        // Vector table: R5 writes, R7 erase, R8 ready after cycle, R11 with serial clock idle
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][41:40] == 2'd0) do_write(VEC[i][39:32], VEC[i][31:16]);
            else                       do_erase(VEC[i][39:32]);
            wait_ready(lows, rdy);
            check("R8 ready after cycle", 32'(rdy), 32'd1);
            peek(VEC[i][39:32], w);
            check((VEC[i][41:40] == 2'd0) ? "R5 R11 word written" : "R7 word erased",
                  32'(w), 32'(VEC[i][15:0]));
        end

        // R6 clear before store, R8 busy level and length
        do_write(8'h10, 16'h0F0F);
        select_dev();
        peek(8'h10, w);
        check("R6 word all ones during write", 32'(w), 32'hFFFF);
        check("R8 busy shown as 0", 32'({sdo_en, sdo}), 32'b10);
        lows = 0;
        rdy  = 1'b0;
        for (int i = 0; i < 2000 && !rdy; i++) begin
            @(negedge clk);
            if (sdo_en && !sdo) lows++;
            if (sdo_en && sdo)  rdy = 1'b1;
        end
        deselect_dev();
        check("R8 busy length in window", 32'((lows >= PROG - 14) && (lows <= PROG)), 32'd1);
        peek(8'h10, w);
        check("R5 stored after cycle", 32'(w), 32'h0F0F);

        // R10 erase sent mid-cycle is ignored
        do_write(8'h20, 16'hAAAA);
        do_erase(8'h21);
        wait_ready(lows, rdy);
        peek(8'h21, w);
        check("R10 erase during busy ignored", 32'(w), 32'h5A5A);
        peek(8'h20, w);
        check("R10 first write completed", 32'(w), 32'hAAAA);
        select_dev();
        repeat (4) @(negedge clk);
        check("R10 no second cycle", 32'({sdo_en, sdo}), 32'b11);
        deselect_dev();

        // R4 disable, unrecognised code, re-enable
        do_ctrl(2'b00);
        do_write(8'h20, 16'h1357);
        select_dev();
        repeat (4) @(negedge clk);
        check("R4 no cycle after disable", 32'(sdo_en), 32'd0);
        deselect_dev();
        peek(8'h20, w);
        check("R4 word kept after disable", 32'(w), 32'hAAAA);
        do_ctrl(2'b01);
        do_write(8'h20, 16'h2468);
        peek(8'h20, w);
        check("R4 code 01 leaves disabled", 32'(w), 32'hAAAA);
        do_ctrl(2'b11);
        do_erase(8'h20);
        wait_ready(lows, rdy);
        peek(8'h20, w);
        check("R7 R4 erase after re-enable", 32'(w), 32'hFFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule